// File: doc/BRIEF.md
# SECDED Memory Word Protection

This block guards one 72-bit memory word, which holds 64 data bits and 8 check bits. On the write side it works out the check bits combinationally from the data that is about to be stored. On the read side it takes the stored word and computes a Hamming syndrome and an overall parity. From these it repairs any single flipped bit before the data leaves the block. A word with two flipped bits is marked uncorrectable, and its data is passed on untouched instead of being miscorrected.

The read path has one register stage. Each word entered with a valid strobe comes out, corrected, on the next clock. A new word can be accepted on every cycle, so a burst streams through at full rate. Correction is always applied. The reporting controls only decide whether an interrupt request is raised. Single-error and double-error requests have separate enables. Two sticky flags record that an event of each kind has occurred. Each flag clears when a one is written to its clear input.

Top module: `secded_word_guard`

## Requirements
- R1: The stored word is `{check[7:0], data[63:0]}`. Data bit i has Hamming position equal to the i-th integer, counting from 3, that is not a power of two. Check bit k (k = 0..6, word bit 64+k) has position 2^k. Bit 7 (word bit 71) is even parity over the other 71 bits. `wr_check_o` is chosen so that the XOR of the positions of all set bits is zero.
- R2: `rd_valid_o` equals `rd_valid_i` delayed by exactly one clock. Back-to-back words are each reported, one per cycle.
- R3: A word with no error gives its data unchanged, a zero syndrome, and neither error flag.
- R4: A word with one flipped data bit gives the corrected data. The syndrome equals that bit's position, and `rd_single_o` is set.
- R5: A word with one flipped check bit gives its data unchanged and sets `rd_single_o`. The syndrome is 2^k for check bit k, or 0 for the overall parity bit.
- R6: A word with two flipped bits sets `rd_double_o`. The syndrome is the XOR of the two positions, and the received data bits are output without modification.
- R7: When overall parity is odd but the syndrome is above 71 (no existing position), the word is flagged as `rd_double_o`, and its data passes through unmodified.
- R8: Correction of data does not depend on the interrupt enables.
- R9: `irq_o` is high in the same cycle as a flagged word exactly when (`rd_single_o` and the single enable) or (`rd_double_o` and the double enable). Both enables are sampled together with the word.
- R10: `sticky_single_o` and `sticky_double_o` set in the cycle the matching flag is reported. They hold until their clear input is high for a cycle. A new event in the same cycle as a clear keeps the flag set.
- R11: After reset every output of the read path is 0.
- R12: `rd_single_o` and `rd_double_o` are never high together. Neither flag, nor `irq_o`, nor a sticky change occurs for a cycle in which no word was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 64 | Data about to be stored |
| wr_check_o | output | 8 | Check bits for `wr_data_i` |
| rd_valid_i | input | 1 | A read word is present this cycle |
| rd_word_i | input | 72 | Word read from memory |
| irq_single_en_i | input | 1 | Raise the interrupt on corrected errors |
| irq_double_en_i | input | 1 | Raise the interrupt on uncorrectable errors |
| clr_single_i | input | 1 | Write-one clear of the single-error sticky flag |
| clr_double_i | input | 1 | Write-one clear of the double-error sticky flag |
| rd_valid_o | output | 1 | Corrected word present |
| rd_data_o | output | 64 | Corrected data |
| rd_syndrome_o | output | 7 | Hamming syndrome of the word |
| rd_single_o | output | 1 | Word had a corrected single error |
| rd_double_o | output | 1 | Word had an uncorrectable error |
| irq_o | output | 1 | Interrupt request for this word |
| sticky_single_o | output | 1 | A single error has been seen since the last clear |
| sticky_double_o | output | 1 | An uncorrectable error has been seen since the last clear |

## Verification
The bench flips every one of the 72 bits of several data patterns, and every pair of bits of two patterns, with the words streamed back to back. A decoder with a wrong position table would repair the wrong bit or report the wrong syndrome. A decoder that trusted a nonzero syndrome alone would "correct" double errors into a third bad bit. Flips of the check bits and of the overall parity bit are covered as well, since a design that mapped them onto data would corrupt clean data. The bench also drives a triple error whose syndrome points past the last position, which a naive decoder would index out of range. In the sticky sequence, a clear and an event arrive together, so a design that let the clear win would lose the event.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest r with 2^r >= data + r + 1.
    function automatic int unsigned pos_bits(input int unsigned data_w);
        int unsigned r;
        r = 1;
        while ((32'd1 << r) < data_w + r + 1) r++;
        return r;
    endfunction

    // Hamming position of data bit idx: idx-th non-power-of-two from 3.
    function automatic int unsigned data_pos(input int unsigned idx);
        int unsigned cnt;
        int unsigned p;
        int unsigned res;
        cnt = 0;
        p   = 2;
        res = 0;
        while (cnt <= idx) begin
            p++;
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    typedef enum logic [1:0] {
        FIX_NONE  = 2'd0,
        FIX_DATA  = 2'd1,
        FIX_CHECK = 2'd2,
        FIX_FAIL  = 2'd3
    } fix_kind_e;

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned POS_W  = secded_pkg::pos_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [POS_W:0]    check_o
);

    logic [POS_W-1:0] pos_tbl [DATA_W];
    logic [POS_W-1:0] par;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pos
        assign pos_tbl[i] = POS_W'(secded_pkg::data_pos(i));
    end

    // XOR of positions of set data bits yields each position-parity bit.
    always_comb begin
        par = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) par = par ^ pos_tbl[i];
        end
        check_o = {^{par, data_i}, par};
    end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned POS_W  = secded_pkg::pos_bits(DATA_W),
    parameter int unsigned WORD_W = DATA_W + POS_W + 1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [POS_W-1:0]  syn_o,
    output logic              odd_o
);

    logic [POS_W-1:0] pos_tbl [DATA_W];
    logic [POS_W-1:0] acc;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pos
        assign pos_tbl[i] = POS_W'(secded_pkg::data_pos(i));
    end

    always_comb begin
        acc = word_i[DATA_W +: POS_W];
        for (int i = 0; i < DATA_W; i++) begin
            if (word_i[i]) acc = acc ^ pos_tbl[i];
        end
        syn_o = acc;
        odd_o = ^word_i;
    end

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned POS_W  = secded_pkg::pos_bits(DATA_W)
) (
    input  logic [DATA_W-1:0]         data_i,
    input  logic [POS_W-1:0]          syn_i,
    input  logic                      odd_i,
    output logic [DATA_W-1:0]         data_o,
    output secded_pkg::fix_kind_e     kind_o
);

    localparam logic [POS_W-1:0] MAX_POS = POS_W'(DATA_W + POS_W);

    logic [POS_W-1:0]  pos_tbl [DATA_W];
    logic [DATA_W-1:0] flip;
    logic              syn_zero;
    logic              syn_pow2;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pos
        assign pos_tbl[i] = POS_W'(secded_pkg::data_pos(i));
        assign flip[i]    = (syn_i == pos_tbl[i]);
    end

    always_comb begin
        syn_zero = (syn_i == '0);
        syn_pow2 = ((syn_i & (syn_i - POS_W'(1))) == '0);
        if (!odd_i) begin
            kind_o = syn_zero ? secded_pkg::FIX_NONE : secded_pkg::FIX_FAIL;
        end else if (syn_pow2) begin
            kind_o = secded_pkg::FIX_CHECK;
        end else if (syn_i > MAX_POS) begin
            kind_o = secded_pkg::FIX_FAIL;
        end else begin
            kind_o = secded_pkg::FIX_DATA;
        end
        data_o = (kind_o == secded_pkg::FIX_DATA) ? (data_i ^ flip) : data_i;
    end

endmodule

// File: rtl/secded_word_guard.sv
module secded_word_guard #(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned POS_W  = secded_pkg::pos_bits(DATA_W),
    localparam int unsigned WORD_W = DATA_W + POS_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [POS_W:0]    wr_check_o,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_word_i,
    input  logic              irq_single_en_i,
    input  logic              irq_double_en_i,
    input  logic              clr_single_i,
    input  logic              clr_double_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [POS_W-1:0]  rd_syndrome_o,
    output logic              rd_single_o,
    output logic              rd_double_o,
    output logic              irq_o,
    output logic              sticky_single_o,
    output logic              sticky_double_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [POS_W-1:0]  syn;
        logic              single;
        logic              dbl;
        logic              irq;
        logic              st_single;
        logic              st_double;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [POS_W-1:0]      syn;
    logic                  odd;
    logic [DATA_W-1:0]     fixed_data;
    secded_pkg::fix_kind_e kind;
    logic                  hit_single;
    logic                  hit_double;

    secded_encoder #(.DATA_W(DATA_W), .POS_W(POS_W)) enc_i (
        .data_i  (wr_data_i),
        .check_o (wr_check_o)
    );

    secded_syndrome #(.DATA_W(DATA_W), .POS_W(POS_W), .WORD_W(WORD_W)) syn_i (
        .word_i (rd_word_i),
        .syn_o  (syn),
        .odd_o  (odd)
    );

    secded_corrector #(.DATA_W(DATA_W), .POS_W(POS_W)) fix_i (
        .data_i (rd_word_i[DATA_W-1:0]),
        .syn_i  (syn),
        .odd_i  (odd),
        .data_o (fixed_data),
        .kind_o (kind)
    );

    always_comb begin
        hit_single = rd_valid_i &&
                     (kind == secded_pkg::FIX_DATA || kind == secded_pkg::FIX_CHECK);
        hit_double = rd_valid_i && (kind == secded_pkg::FIX_FAIL);

        stage_d           = stage_q;
        stage_d.valid     = rd_valid_i;
        stage_d.data      = fixed_data;
        stage_d.syn       = rd_valid_i ? syn : '0;
        stage_d.single    = hit_single;
        stage_d.dbl       = hit_double;
        stage_d.irq       = (hit_single && irq_single_en_i) ||
                            (hit_double && irq_double_en_i);
        stage_d.st_single = (stage_q.st_single && !clr_single_i) || hit_single;
        stage_d.st_double = (stage_q.st_double && !clr_double_i) || hit_double;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rd_valid_o      = stage_q.valid;
    assign rd_data_o       = stage_q.data;
    assign rd_syndrome_o   = stage_q.syn;
    assign rd_single_o     = stage_q.single;
    assign rd_double_o     = stage_q.dbl;
    assign irq_o           = stage_q.irq;
    assign sticky_single_o = stage_q.st_single;
    assign sticky_double_o = stage_q.st_double;

endmodule

// File: rtl/secded_word_guard_chk.sv
module secded_word_guard_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned POS_W  = secded_pkg::pos_bits(DATA_W)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [POS_W:0]    wr_check_o,
    input logic              rd_valid_i,
    input logic [DATA_W-1:0] rd_word_data,
    input logic              irq_single_en_i,
    input logic              irq_double_en_i,
    input logic              clr_single_i,
    input logic              clr_double_i,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [POS_W-1:0]  rd_syndrome_o,
    input logic              rd_single_o,
    input logic              rd_double_o,
    input logic              irq_o,
    input logic              sticky_single_o,
    input logic              sticky_double_o
);

    a_r1_even_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (^{wr_check_o, wr_data_i}) == 1'b0);

    a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_i |=> rd_valid_o);

    a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_i |=> !rd_valid_o);

    a_r3_clean_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_single_o && !rd_double_o) |->
        (rd_syndrome_o == '0 && rd_data_o == $past(rd_word_data)));

    a_r6_raw_on_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_double_o |-> (rd_data_o == $past(rd_word_data)));

    a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((rd_single_o && $past(irq_single_en_i)) ||
                   (rd_double_o && $past(irq_double_en_i))));

    a_r9_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_single_o && $past(irq_single_en_i)) ||
         (rd_double_o && $past(irq_double_en_i))) |-> irq_o);

    a_r10_single_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_single_o |-> sticky_single_o);

    a_r10_double_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_double_o |-> sticky_double_o);

    a_r10_single_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sticky_single_o) |-> $past(clr_single_i));

    a_r10_double_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sticky_double_o) |-> $past(clr_double_i));

    a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_single_o && rd_double_o));

    a_r12_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_single_o || rd_double_o || irq_o) |-> rd_valid_o);

endmodule

bind secded_word_guard secded_word_guard_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_data_i       (wr_data_i),
    .wr_check_o      (wr_check_o),
    .rd_valid_i      (rd_valid_i),
    .rd_word_data    (rd_word_i[DATA_W-1:0]),
    .irq_single_en_i (irq_single_en_i),
    .irq_double_en_i (irq_double_en_i),
    .clr_single_i    (clr_single_i),
    .clr_double_i    (clr_double_i),
    .rd_valid_o      (rd_valid_o),
    .rd_data_o       (rd_data_o),
    .rd_syndrome_o   (rd_syndrome_o),
    .rd_single_o     (rd_single_o),
    .rd_double_o     (rd_double_o),
    .irq_o           (irq_o),
    .sticky_single_o (sticky_single_o),
    .sticky_double_o (sticky_double_o)
);

// File: tb/secded_word_guard_tb_top.sv
module secded_word_guard_tb_top;

    localparam int DW = 64;
    localparam int PW = 7;
    localparam int WW = 72;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic [PW:0]   wr_check_o;
    logic          rd_valid_i = 1'b0;
    logic [WW-1:0] rd_word_i = '0;
    logic          irq_single_en_i = 1'b0;
    logic          irq_double_en_i = 1'b0;
    logic          clr_single_i = 1'b0;
    logic          clr_double_i = 1'b0;
    logic          rd_valid_o;
    logic [DW-1:0] rd_data_o;
    logic [PW-1:0] rd_syndrome_o;
    logic          rd_single_o;
    logic          rd_double_o;
    logic          irq_o;
    logic          sticky_single_o;
    logic          sticky_double_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5ns clk_i = ~clk_i;

    secded_word_guard dut_i (
        .clk_i, .rst_ni, .wr_data_i, .wr_check_o, .rd_valid_i, .rd_word_i,
        .irq_single_en_i, .irq_double_en_i, .clr_single_i, .clr_double_i,
        .rd_valid_o, .rd_data_o, .rd_syndrome_o, .rd_single_o, .rd_double_o,
        .irq_o, .sticky_single_o, .sticky_double_o
    );

    // Position rule of R1, computed independently.
    function automatic int bpos(input int idx);
        int c = -1;
        for (int p = 3; p < 256; p++) begin
            if ((p & (p - 1)) != 0) begin
                c++;
                if (c == idx) return p;
            end
        end
        return 0;
    endfunction

    function automatic logic [PW-1:0] word_bit_pos(input int b);
        if (b < DW) return PW'(bpos(b));
        if (b < DW + PW) return PW'(1 << (b - DW));
        return '0;
    endfunction

    function automatic logic [PW:0] ref_check(input logic [DW-1:0] d);
        logic [PW:0] c = '0;
        for (int i = 0; i < DW; i++)
            for (int k = 0; k < PW; k++)
                if (d[i] && ((bpos(i) >> k) & 1) == 1) c[k] = ~c[k];
        c[PW] = ^{c[PW-1:0], d};
        return c;
    endfunction

    // Pending expectation for the word driven at the previous negedge.
    logic          p_v = 0, p_s = 0, p_d = 0, p_irq = 0, p_ss = 0, p_sd = 0;
    logic [DW-1:0] p_data = '0;
    logic [PW-1:0] p_syn = '0;
    string         p_req = "R11";
    logic          m_ss = 0, m_sd = 0;

    task automatic compare_pending();
        bit bad;
        bad = (rd_valid_o !== p_v) || (rd_single_o !== p_s) || (rd_double_o !== p_d) ||
              (irq_o !== p_irq) || (sticky_single_o !== p_ss) ||
              (sticky_double_o !== p_sd) ||
              (p_v && ((rd_data_o !== p_data) || (rd_syndrome_o !== p_syn)));
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: actual v=%0b data=%h syn=%h s=%0b d=%0b irq=%0b st=%0b%0b expected v=%0b data=%h syn=%h s=%0b d=%0b irq=%0b st=%0b%0b",
                     p_req, rd_valid_o, rd_data_o, rd_syndrome_o, rd_single_o, rd_double_o,
                     irq_o, sticky_single_o, sticky_double_o, p_v, p_data, p_syn, p_s, p_d,
                     p_irq, p_ss, p_sd);
        end
    endtask

    task automatic step(input logic v, input logic [WW-1:0] w, input logic es, input logic ed,
                        input logic cs, input logic cd, input logic [DW-1:0] e_data,
                        input logic [PW-1:0] e_syn, input logic e_s, input logic e_d,
                        input string req);
        @(negedge clk_i);
        compare_pending();
        rd_valid_i      = v;
        rd_word_i       = w;
        irq_single_en_i = es;
        irq_double_en_i = ed;
        clr_single_i    = cs;
        clr_double_i    = cd;
        p_v    = v;
        p_data = e_data;
        p_syn  = e_syn;
        p_s    = v & e_s;
        p_d    = v & e_d;
        p_irq  = (p_s & es) | (p_d & ed);
        m_ss   = (m_ss & ~cs) | p_s;
        m_sd   = (m_sd & ~cd) | p_d;
        p_ss   = m_ss;
        p_sd   = m_sd;
        p_req  = req;
    endtask

    task automatic enc_check(input logic [DW-1:0] d);
        logic [PW:0] exp_c;
        wr_data_i = d;
        #1ns;
        exp_c = ref_check(d);
        checks++;
        if (wr_check_o !== exp_c) begin
            errors++;
            $display("FAIL R1: data=%h actual check=%h expected check=%h", d, wr_check_o, exp_c);
        end
    endtask

    logic [DW-1:0] pats [5];

    initial begin
        logic [WW-1:0] cw;
        logic [WW-1:0] w;
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'hA5A5_5A5A_C3C3_3C3C;
        pats[3] = 64'h0123_4567_89AB_CDEF;
        pats[4] = 64'h8000_0000_0000_0001;

        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: encoder on every pattern plus walking ones.
        for (int p = 0; p < 5; p++) enc_check(pats[p]);
        for (int i = 0; i < DW; i += 7) enc_check(64'h1 << i);

        // R3: clean words, streamed back to back (R2).
        for (int p = 0; p < 5; p++) begin
            cw = {ref_check(pats[p]), pats[p]};
            step(1, cw, 1, 1, 0, 0, pats[p], '0, 0, 0, "R3");
        end
        // R12: invalid cycle with a corrupted word on the bus.
        cw = {ref_check(pats[2]), pats[2]};
        step(0, cw ^ 72'h3, 1, 1, 0, 0, '0, '0, 0, 0, "R12");

        // R4/R5 single flips; enables vary per pattern (R8, R9).
        for (int p = 0; p < 5; p++) begin
            cw = {ref_check(pats[p]), pats[p]};
            for (int b = 0; b < WW; b++) begin
                w = cw ^ (72'h1 << b);
                step(1, w, p[0], p[1], 0, 0, pats[p], word_bit_pos(b), 1, 0,
                     (b < DW) ? "R4/R8/R9" : "R5/R8/R9");
            end
        end

        // R10: clear single flag; double flag never set yet.
        step(0, '0, 0, 0, 1, 0, '0, '0, 0, 0, "R10");

        // R6 double flips on two patterns with opposite enables (R9).
        for (int q = 0; q < 2; q++) begin
            int p = (q == 0) ? 0 : 3;
            cw = {ref_check(pats[p]), pats[p]};
            for (int a = 0; a < WW; a++) begin
                for (int b = a + 1; b < WW; b++) begin
                    w = cw ^ (72'h1 << a) ^ (72'h1 << b);
                    step(1, w, q[0], ~q[0], 0, 0, w[DW-1:0],
                         word_bit_pos(a) ^ word_bit_pos(b), 0, 1, "R6/R9");
                end
            end
        end

        // R7: triple flip, syndrome 72 points past the last position.
        cw = {ref_check(pats[0]), pats[0]};
        w  = cw ^ (72'h1 << (DW + 3)) ^ (72'h1 << (DW + 6)) ^ (72'h1 << 71);
        step(1, w, 0, 1, 0, 0, w[DW-1:0], 7'd72, 0, 1, "R7");

        // R10: new double event with a clear in the same cycle keeps it set.
        w = cw ^ 72'h5;
        step(1, w, 0, 0, 0, 1, w[DW-1:0], word_bit_pos(0) ^ word_bit_pos(2), 0, 1, "R10");
        step(0, '0, 0, 0, 0, 1, '0, '0, 0, 0, "R10");
        // R10: single event with clear together, then hold without clear.
        w = cw ^ (72'h1 << 10);
        step(1, w, 1, 0, 1, 0, pats[0], word_bit_pos(10), 1, 0, "R10");
        step(1, cw, 0, 0, 0, 0, pats[0], '0, 0, 0, "R10/R3");
        step(0, '0, 0, 0, 0, 0, '0, '0, 0, 0, "R2");
        @(negedge clk_i);
        compare_pending();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2: watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule